// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Expander

This block takes 96 interrupt request lines, split into 12 groups of 8, and turns them into one prioritised interrupt request with a vector index for a processor core. The first level works per group. The rising edge of a request line sets a bit in that group's flag register. An 8-bit enable register decides which flagged lines count. A per-group acknowledge latch lets only one request from that group up to the second level until software releases the latch.

The second level holds one flag bit and one enable bit per group, plus a global mask. When the mask is clear and an enabled second-level flag is set, the block raises its request. The vector points at the highest-priority line of the highest-priority group. When the core acknowledges, the serviced line's group flag and that group's second-level flag are cleared together. Software reaches every register through a simple single-cycle write port and a combinational read port. Writing a group flag bit directly makes that line act as a software interrupt.

Top module: `irq_expander`

## Requirements
- R1: After reset, all group flags, group enables, second-level flags and second-level enables read 0, all acknowledge latches read 0, the global mask reads 1 and `cpu_irq` is low.
- R2: A 0-to-1 transition on `irq_in[g*8+l]` sets group flag bit l of group g at the first rising clock edge where the line is high. A line held high does not set the bit again after it has been cleared.
- R3: A group whose flags ANDed with its enables are non-zero, and whose acknowledge latch is clear, sets its second-level flag bit and its acknowledge latch at the next clock edge. A group with no enabled flag forwards nothing.
- R4: While a group's acknowledge latch is set, that group forwards no new request. Writing 1 to a bit of the acknowledge register (address 32) clears that latch, and writing 0 leaves it unchanged.
- R5: `cpu_irq` is high only when the global mask (address 35, bit 0, 1 = masked) is 0 and some second-level flag bit has its enable bit (address 34) set.
- R6: Among the second-level requests that are enabled, the lowest group index wins.
- R7: Within the winning group, the lowest line index whose flag and enable are both set is reported.
- R8: `cpu_vec` equals group*8 + line, counting both from 0, so it ranges from 0 to 95.
- R9: A clock edge with `cpu_ack` and `cpu_irq` both high clears the reported group flag bit and the winning group's second-level flag bit. A hardware set in that same cycle takes precedence.
- R10: A register write to a group flag (address g, g = 0..11) loads the written value. A bit set this way behaves like a captured edge.
- R11: The address map is as follows. Group flags sit at 0..11, group enables at 16..27, the acknowledge latches at 32, second-level flags at 33, second-level enables at 34 and the mask at 35. Writes to other addresses have no effect, and reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 96 | Request lines; line l of group g is bit g*8+l |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Combinational read data for `reg_addr` |
| cpu_irq | output | 1 | Prioritised interrupt request |
| cpu_vec | output | 7 | Vector index of the reported line |
| cpu_ack | input | 1 | Acknowledge of the reported vector |

## Verification
A rising request line shows in its group flag one edge after it is driven. The request reaches `cpu_irq` and the acknowledge latch one edge later, so two edges after the line rises. A register write takes effect at its own edge. A change to the mask or to a second-level enable changes `cpu_irq` right after that edge, because the output is combinational from registers. An acknowledge clears its flags at the acknowledge edge, and the next winner is visible right after it. The bench drives every input one nanosecond after a rising edge and reads results in the same window. Each check is placed exactly the number of edges listed above after its stimulus.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  // register bank selected by the upper two address bits
  typedef enum logic [1:0] {
    BANK_FLAG = 2'd0,
    BANK_EN   = 2'd1,
    BANK_CTRL = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  // low-address selector inside BANK_CTRL
  localparam int CTRL_ACK   = 0;
  localparam int CTRL_CFLAG = 1;
  localparam int CTRL_CEN   = 2;
  localparam int CTRL_MASK  = 3;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_grp.sv
module irq_grp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] irq_in,
  input  logic         flag_wr,
  input  logic         en_wr,
  input  logic         ack_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] svc_clr,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] en_q,
  output logic         ack_q,
  output logic         fwd
);
  logic [W-1:0] irq_d_q;
  logic [W-1:0] rise;
  logic [W-1:0] flag_d;
  logic [W-1:0] en_d;
  logic         ack_d;

  always_comb begin
    rise   = irq_in & ~irq_d_q;
    flag_d = ((flag_wr ? wdata : flag_q) & ~svc_clr) | rise;
    en_d   = en_wr ? wdata : en_q;
    fwd    = (|(flag_q & en_q)) & ~ack_q;
    ack_d  = (ack_q & ~ack_clr) | fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d_q <= '0;
      flag_q  <= '0;
      en_q    <= '0;
      ack_q   <= 1'b0;
    end else begin
      irq_d_q <= irq_in;
      flag_q  <= flag_d;
      if (en_wr) en_q <= en_d;
      ack_q   <= ack_d;
    end
  end
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int NUM_GRP = 12,
  parameter int GRP_W   = 8,
  localparam int NUM_SRC = NUM_GRP * GRP_W,
  localparam int VEC_W   = $clog2(NUM_SRC),
  localparam int GIW     = $clog2(NUM_GRP),
  localparam int LIW     = $clog2(GRP_W),
  localparam int IDX_W   = (GIW > 2) ? GIW : 2,
  localparam int ADDR_W  = IDX_W + 2,
  localparam int DATA_W  = (GRP_W > NUM_GRP) ? GRP_W : NUM_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vec,
  input  logic               cpu_ack
);
  import irq_exp_pkg::*;

  logic [NUM_GRP-1:0][GRP_W-1:0] grp_flag, grp_en, svc_line;
  logic [NUM_GRP-1:0]            ack, fwd;
  logic [NUM_GRP-1:0]            cflag_q, cflag_d, cen_q, cen_d, svc_grp;
  logic                          gmask_q, gmask_d;

  bank_e             bank;
  logic [IDX_W-1:0]  idx;
  logic              grp_idx_ok;
  logic              ctl_wr;

  logic              grp_found, line_found;
  logic [GIW-1:0]    win_grp;
  logic [LIW-1:0]    win_line;
  logic              svc;

  assign bank       = bank_e'(reg_addr[ADDR_W-1 -: 2]);
  assign idx        = reg_addr[IDX_W-1:0];
  assign grp_idx_ok = (32'(idx) < NUM_GRP);
  assign ctl_wr     = reg_wr && (bank == BANK_CTRL);

  // group level
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic sel_g;
    assign sel_g = (32'(idx) == g);
    assign svc_line[g] = (svc && line_found && (win_grp == GIW'(g)))
                         ? (GRP_W'(1) << win_line) : '0;
    assign svc_grp[g]  = svc && (win_grp == GIW'(g));

    irq_grp #(.W(GRP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in[g*GRP_W +: GRP_W]),
      .flag_wr (reg_wr && bank == BANK_FLAG && sel_g),
      .en_wr   (reg_wr && bank == BANK_EN && sel_g),
      .ack_clr (ctl_wr && 32'(idx) == CTRL_ACK && reg_wdata[g]),
      .wdata   (reg_wdata[GRP_W-1:0]),
      .svc_clr (svc_line[g]),
      .flag_q  (grp_flag[g]),
      .en_q    (grp_en[g]),
      .ack_q   (ack[g]),
      .fwd     (fwd[g])
    );
  end

  // arbitration
  irq_prio_enc #(.N(NUM_GRP)) u_grp_pri (
    .req   (cflag_q & cen_q),
    .found (grp_found),
    .idx   (win_grp)
  );

  irq_prio_enc #(.N(GRP_W)) u_line_pri (
    .req   (grp_flag[win_grp] & grp_en[win_grp]),
    .found (line_found),
    .idx   (win_line)
  );

  assign cpu_irq = grp_found && !gmask_q;
  assign cpu_vec = VEC_W'(win_grp) * VEC_W'(GRP_W) + VEC_W'(win_line);
  assign svc     = cpu_irq && cpu_ack;

  // CPU level next state
  always_comb begin
    cflag_d = cflag_q;
    cen_d   = cen_q;
    gmask_d = gmask_q;
    if (ctl_wr && 32'(idx) == CTRL_CFLAG) cflag_d = reg_wdata[NUM_GRP-1:0];
    if (ctl_wr && 32'(idx) == CTRL_CEN)   cen_d   = reg_wdata[NUM_GRP-1:0];
    if (ctl_wr && 32'(idx) == CTRL_MASK)  gmask_d = reg_wdata[0];
    cflag_d = (cflag_d & ~svc_grp) | fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag_q <= '0;
      cen_q   <= '0;
      gmask_q <= 1'b1;
    end else begin
      cflag_q <= cflag_d;
      if (ctl_wr) begin
        cen_q   <= cen_d;
        gmask_q <= gmask_d;
      end
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (bank)
      BANK_FLAG: if (grp_idx_ok) reg_rdata = DATA_W'(grp_flag[idx]);
      BANK_EN:   if (grp_idx_ok) reg_rdata = DATA_W'(grp_en[idx]);
      BANK_CTRL: begin
        case (32'(idx))
          CTRL_ACK:   reg_rdata = DATA_W'(ack);
          CTRL_CFLAG: reg_rdata = DATA_W'(cflag_q);
          CTRL_CEN:   reg_rdata = DATA_W'(cen_q);
          CTRL_MASK:  reg_rdata = DATA_W'(gmask_q);
          default:    reg_rdata = '0;
        endcase
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk #(
  parameter int NUM_GRP = 12,
  parameter int GRP_W   = 8,
  localparam int NUM_SRC = NUM_GRP * GRP_W,
  localparam int VEC_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_irq,
  input logic               cpu_ack,
  input logic [VEC_W-1:0]   cpu_vec,
  input logic               gmask,
  input logic [NUM_GRP-1:0] cpu_en,
  input logic [NUM_GRP-1:0] cpu_flag,
  input logic [NUM_GRP-1:0] fwd,
  input logic [NUM_GRP-1:0] ack
);
  logic [NUM_GRP-1:0] svc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= (cpu_irq && cpu_ack)
                         ? (NUM_GRP'(1) << (cpu_vec / VEC_W'(GRP_W))) : '0;
  end

  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |-> !cpu_irq);

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> |(cpu_flag & cpu_en));

  assert_ack_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd & ack) == '0);

  assert_fwd_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |fwd |=> (((cpu_flag & $past(fwd)) == $past(fwd)) && ((ack & $past(fwd)) == $past(fwd))));

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (32'(cpu_vec) < NUM_SRC));

  assert_svc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack) |=> ((cpu_flag & svc_q & ~$past(fwd)) == '0));
endmodule

bind irq_expander irq_expander_chk #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_irq  (cpu_irq),
  .cpu_ack  (cpu_ack),
  .cpu_vec  (cpu_vec),
  .gmask    (gmask_q),
  .cpu_en   (cen_q),
  .cpu_flag (cflag_q),
  .fwd      (fwd),
  .ack      (ack)
);

// File: tb/irq_expander_tb.sv
`timescale 1ns/100ps
module irq_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [95:0] irq_in;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [11:0] reg_wdata;
  logic [11:0] reg_rdata;
  logic        cpu_irq;
  logic [6:0]  cpu_vec;
  logic        cpu_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_expander u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
  );

  localparam logic [5:0] A_ACK = 6'd32, A_CFLAG = 6'd33, A_CEN = 6'd34, A_MASK = 6'd35;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [11:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    reg_addr = a;
    #0.2;
    v = int'(reg_rdata);
  endtask

  task automatic service();
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    check("R1", "cpu_irq", int'(cpu_irq), 0);
    rd(A_MASK, v);  check("R1", "mask", v, 1);
    rd(A_CEN, v);   check("R1", "cpu enable", v, 0);
    rd(A_CFLAG, v); check("R1", "cpu flag", v, 0);
    rd(A_ACK, v);   check("R1", "ack", v, 0);
    rd(6'd0, v);    check("R1", "grp0 flag", v, 0);
    rd(6'd27, v);   check("R1", "grp11 enable", v, 0);
  endtask

  task automatic t_edge();
    int v;
    wr(A_CEN, 12'hFFF);
    wr(A_MASK, 12'h000);
    wr(6'd18, 12'h008);
    irq_in[19] = 1'b1;
    step();
    rd(6'd2, v); check("R2", "grp2 flag after edge", v, 8);
    check("R3", "irq not yet", int'(cpu_irq), 0);
    step();
    check("R3", "irq raised", int'(cpu_irq), 1);
    check("R8", "vector", int'(cpu_vec), 19);
    rd(A_ACK, v); check("R3", "ack latch", v, 4);
    service();
    rd(6'd2, v);    check("R9", "grp2 flag cleared", v, 0);
    rd(A_CFLAG, v); check("R9", "cpu flag cleared", v, 0);
    check("R9", "irq dropped", int'(cpu_irq), 0);
    step();
    rd(6'd2, v); check("R2", "held level not recaptured", v, 0);
    irq_in[19] = 1'b0;
  endtask

  task automatic t_ackblock();
    int v;
    wr(6'd18, 12'h028);
    irq_in[21] = 1'b1;
    step();
    irq_in[21] = 1'b0;
    step(); step();
    check("R4", "blocked by ack", int'(cpu_irq), 0);
    rd(6'd2, v); check("R4", "flag waits", v, 32);
    wr(A_ACK, 12'h000);
    step();
    check("R4", "write 0 keeps ack", int'(cpu_irq), 0);
    wr(A_ACK, 12'h004);
    step();
    check("R4", "irq after release", int'(cpu_irq), 1);
    check("R8", "vector", int'(cpu_vec), 21);
    service();
    wr(A_ACK, 12'hFFF);
    check("R4", "idle", int'(cpu_irq), 0);
  endtask

  task automatic t_mask();
    int v;
    wr(A_MASK, 12'h001);
    wr(6'd16, 12'h001);
    wr(6'd0, 12'h001);
    step();
    check("R5", "masked", int'(cpu_irq), 0);
    rd(A_CFLAG, v); check("R10", "software flag forwarded", v, 1);
    wr(A_MASK, 12'h000);
    check("R5", "unmasked", int'(cpu_irq), 1);
    check("R10", "vector", int'(cpu_vec), 0);
    wr(A_CEN, 12'hFFE);
    check("R5", "cpu enable off", int'(cpu_irq), 0);
    wr(A_CEN, 12'hFFF);
    service();
    check("R9", "serviced", int'(cpu_irq), 0);
    wr(A_ACK, 12'hFFF);
  endtask

  task automatic t_prio();
    int v;
    wr(6'd19, 12'h0FF);
    wr(6'd21, 12'h0FF);
    wr(6'd5, 12'h090);
    wr(6'd3, 12'h006);
    step();
    check("R6", "group 3 first", int'(cpu_vec), 25);
    check("R7", "irq", int'(cpu_irq), 1);
    service();
    check("R6", "group 5 next", int'(cpu_vec), 44);
    service();
    check("R4", "both latched", int'(cpu_irq), 0);
    rd(6'd3, v); check("R9", "grp3 flag", v, 4);
    rd(6'd5, v); check("R9", "grp5 flag", v, 128);
    wr(A_ACK, 12'hFFF);
    step();
    check("R7", "grp3 line 2", int'(cpu_vec), 26);
    service();
    check("R7", "grp5 line 7", int'(cpu_vec), 47);
    service();
    wr(A_ACK, 12'hFFF);
    step();
    check("R9", "all drained", int'(cpu_irq), 0);
  endtask

  task automatic t_top();
    int v;
    wr(6'd11, 12'h081);
    step(); step();
    rd(A_ACK, v); check("R3", "disabled group idle", v, 0);
    check("R3", "no irq", int'(cpu_irq), 0);
    wr(6'd27, 12'h080);
    step();
    check("R8", "last vector", int'(cpu_vec), 95);
    service();
    wr(A_ACK, 12'hFFF);
    rd(6'd11, v); check("R9", "line 0 kept", v, 1);
    wr(6'd11, 12'h000);
    rd(6'd11, v); check("R10", "flag write clears", v, 0);
  endtask

  task automatic t_map();
    int v;
    wr(6'd13, 12'h0FF);
    rd(6'd13, v); check("R11", "unused flag slot", v, 0);
    wr(6'd40, 12'hFFF);
    rd(6'd40, v); check("R11", "unused ctrl slot", v, 0);
    rd(A_CEN, v); check("R11", "cpu enable readback", v, 12'hFFF);
    rd(A_MASK, v); check("R11", "mask readback", v, 0);
    check("R11", "no irq", int'(cpu_irq), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; cpu_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_edge();
    t_ackblock();
    t_mask();
    t_prio();
    t_top();
    t_map();
    finish_run();
  end
endmodule